// File: doc/BRIEF.md
# Serial Parameter Register Slave

This block receives configuration words over a three-wire serial port (clock, data, load strobe) and keeps them in eight 8-bit parameter registers. Every rising clock edge shifts one data bit into an 11-bit window, most significant bit first. A word holds a 3-bit register address followed by 8 data bits. When the load strobe is high at a rising edge, the window at that edge is committed to the addressed register: the ten bits shifted in earlier plus the data bit sampled at that same edge. The new register value appears on the outputs at the next falling edge.

The register contents drive a set of named field outputs for the downstream sensor logic: edge mode and direction, gain, a 16-bit exposure value, three kernel weights, the enhancement ratio, invert, bias, zero calibration and offset. Registers may be rewritten at any time. The active-low asynchronous reset clears every register and the shift window.

Top module: `serial_param_slave`

## Requirements
- R1: A word is 11 bits shifted MSB first: bits [10:8] are the register address (0 to 7) and bits [7:0] are the data.
- R2: On a rising edge with load_i high, the word written is formed from the ten bits shifted in before that edge, followed by the sdata_i bit sampled at that edge as bit 0.
- R3: A committed value appears on the outputs at the falling edge after the committing rising edge. The outputs do not change at the rising edge itself.
- R4: A rising edge with load_i low changes no register.
- R5: Address 1 drives edge_mode_o from bit 7, edge_dir_o from bits [6:5] and gain_o from bits [4:0].
- R6: Address 7 drives ratio_o from bits [7:4], invert_o from bit 3 and bias_o from bits [2:0]. Address 0 drives zero_cal_o from bits [7:6] and offset_o from bits [5:0].
- R7: Addresses 4, 5 and 6 drive kern_p_o, kern_m_o and kern_x_o.
- R8: expo_o is {register 2, register 3}, with register 2 as the high byte.
- R9: rst_ni low clears all registers and the shift window to zero at once, without waiting for a clock edge.
- R10: Only the last 11 bits shifted in count. If a load comes after fewer than 11 bits of a new word, the bits left over from earlier traffic (zero after reset) fill the missing positions.
- R11: A load on each of several consecutive rising edges commits a word at each of those edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial and system clock |
| rst_ni | input | 1 | Asynchronous active-low register reset |
| sdata_i | input | 1 | Serial data bit, sampled on the rising edge |
| load_i | input | 1 | Commit strobe, sampled on the rising edge |
| edge_mode_o | output | 1 | Edge mode select |
| edge_dir_o | output | 2 | Edge direction select |
| gain_o | output | 5 | Output gain |
| expo_o | output | 16 | Combined exposure value |
| kern_p_o | output | 8 | Kernel weight P |
| kern_m_o | output | 8 | Kernel weight M |
| kern_x_o | output | 8 | Kernel weight X |
| ratio_o | output | 4 | Enhancement ratio |
| invert_o | output | 1 | Output inversion |
| bias_o | output | 3 | Output bias code |
| zero_cal_o | output | 2 | Zero-point calibration |
| offset_o | output | 6 | Output offset |

## Verification
The bench builds the block with its default 3-bit address and 8-bit data, so all eight registers and every field bit position are reached. The bench compares all outputs twice per clock: just after the rising edge, to confirm the old value is held, and just after the falling edge, to confirm the new value appears. This exposes a commit that lands at the wrong edge. The stimulus includes long runs of serial traffic before a load, loads after only a few bits, back-to-back loads and a reset in the middle of traffic. Together these cover windowing, the leftover bits from earlier traffic, and the reset clearing the shift window.

// File: rtl/spr_pkg.sv
package spr_pkg;
  parameter int unsigned ADDR_W   = 3;
  parameter int unsigned DATA_W   = 8;
  localparam int unsigned WORD_W   = ADDR_W + DATA_W;
  localparam int unsigned NUM_REGS = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] A_OFFS  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EDGE  = 3'd1;
  localparam logic [ADDR_W-1:0] A_EXPHI = 3'd2;
  localparam logic [ADDR_W-1:0] A_EXPLO = 3'd3;
  localparam logic [ADDR_W-1:0] A_KP    = 3'd4;
  localparam logic [ADDR_W-1:0] A_KM    = 3'd5;
  localparam logic [ADDR_W-1:0] A_KX    = 3'd6;
  localparam logic [ADDR_W-1:0] A_MISC  = 3'd7;

  typedef logic [DATA_W-1:0] reg_t;
endpackage

// File: rtl/spr_shifter.sv
module spr_shifter
  import spr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              load_i,
  output logic              pend_vld_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output reg_t              pend_data_o
);
  logic [WORD_W-2:0] sh_q;
  logic [WORD_W-1:0] word;

  // incoming bit completes the word at the load edge
  assign word = {sh_q, sdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q        <= '0;
      pend_vld_o  <= 1'b0;
      pend_addr_o <= '0;
      pend_data_o <= '0;
    end else begin
      sh_q       <= word[WORD_W-2:0];
      pend_vld_o <= load_i;
      if (load_i) begin
        pend_addr_o <= word[WORD_W-1:DATA_W];
        pend_data_o <= word[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/spr_regfile.sv
module spr_regfile
  import spr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pend_vld_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  input  reg_t              pend_data_i,
  output reg_t              regs_o [NUM_REGS]
);
  // commit on the falling edge after capture
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_o[g] <= '0;
      end else if (pend_vld_i && (pend_addr_i == ADDR_W'(g))) begin
        regs_o[g] <= pend_data_i;
      end
    end
  end
endmodule

// File: rtl/spr_fields.sv
module spr_fields
  import spr_pkg::*;
(
  input  reg_t        regs_i [NUM_REGS],
  output logic        edge_mode_o,
  output logic [1:0]  edge_dir_o,
  output logic [4:0]  gain_o,
  output logic [15:0] expo_o,
  output logic [7:0]  kern_p_o,
  output logic [7:0]  kern_m_o,
  output logic [7:0]  kern_x_o,
  output logic [3:0]  ratio_o,
  output logic        invert_o,
  output logic [2:0]  bias_o,
  output logic [1:0]  zero_cal_o,
  output logic [5:0]  offset_o
);
  always_comb begin
    {edge_mode_o, edge_dir_o, gain_o} = regs_i[A_EDGE];
    expo_o                            = {regs_i[A_EXPHI], regs_i[A_EXPLO]};
    kern_p_o                          = regs_i[A_KP];
    kern_m_o                          = regs_i[A_KM];
    kern_x_o                          = regs_i[A_KX];
    {ratio_o, invert_o, bias_o}       = regs_i[A_MISC];
    {zero_cal_o, offset_o}            = regs_i[A_OFFS];
  end
endmodule

// File: rtl/serial_param_slave.sv
module serial_param_slave
  import spr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sdata_i,
  input  logic        load_i,
  output logic        edge_mode_o,
  output logic [1:0]  edge_dir_o,
  output logic [4:0]  gain_o,
  output logic [15:0] expo_o,
  output logic [7:0]  kern_p_o,
  output logic [7:0]  kern_m_o,
  output logic [7:0]  kern_x_o,
  output logic [3:0]  ratio_o,
  output logic        invert_o,
  output logic [2:0]  bias_o,
  output logic [1:0]  zero_cal_o,
  output logic [5:0]  offset_o
);
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  reg_t              pend_data;
  reg_t              regs [NUM_REGS];

  spr_shifter i_shifter (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sdata_i     (sdata_i),
    .load_i      (load_i),
    .pend_vld_o  (pend_vld),
    .pend_addr_o (pend_addr),
    .pend_data_o (pend_data)
  );

  spr_regfile i_regfile (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_vld_i  (pend_vld),
    .pend_addr_i (pend_addr),
    .pend_data_i (pend_data),
    .regs_o      (regs)
  );

  spr_fields i_fields (
    .regs_i      (regs),
    .edge_mode_o (edge_mode_o),
    .edge_dir_o  (edge_dir_o),
    .gain_o      (gain_o),
    .expo_o      (expo_o),
    .kern_p_o    (kern_p_o),
    .kern_m_o    (kern_m_o),
    .kern_x_o    (kern_x_o),
    .ratio_o     (ratio_o),
    .invert_o    (invert_o),
    .bias_o      (bias_o),
    .zero_cal_o  (zero_cal_o),
    .offset_o    (offset_o)
  );
endmodule

// File: rtl/spr_chk.sv
module spr_chk
  import spr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              pend_vld_i,
  input logic [ADDR_W-1:0] pend_addr_i,
  input reg_t              pend_data_i,
  input logic [4:0]        gain_o,
  input logic [15:0]       expo_o,
  input logic [7:0]        kern_x_o,
  input logic              invert_o,
  input logic [5:0]        offset_o
);
  // R9
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      rst_clear_chk: assert (expo_o == '0 && gain_o == '0 && kern_x_o == '0 && offset_o == '0);
    end
  end

  // R4
  no_load_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> ($stable(expo_o) && $stable(gain_o) && $stable(kern_x_o) && $stable(offset_o)));

  // R8
  expo_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_vld_i && pend_addr_i == A_EXPHI) |-> (expo_o[15:8] == pend_data_i));

  // R5
  gain_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_vld_i && pend_addr_i == A_EDGE) |-> (gain_o == pend_data_i[4:0]));

  // R6
  invert_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_vld_i && pend_addr_i == A_MISC) |-> (invert_o == pend_data_i[3]));

  // R7
  kern_x_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_vld_i && pend_addr_i == A_KX) |-> (kern_x_o == pend_data_i));
endmodule

bind serial_param_slave spr_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .pend_vld_i  (pend_vld),
  .pend_addr_i (pend_addr),
  .pend_data_i (pend_data),
  .gain_o      (gain_o),
  .expo_o      (expo_o),
  .kern_x_o    (kern_x_o),
  .invert_o    (invert_o),
  .offset_o    (offset_o)
);

// File: tb/test_serial_param_slave.sv
module test_serial_param_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0;
  logic load = 1'b0;

  logic        edge_mode;
  logic [1:0]  edge_dir;
  logic [4:0]  gain;
  logic [15:0] expo;
  logic [7:0]  kp, km, kx;
  logic [3:0]  ratio;
  logic        invert;
  logic [2:0]  bias;
  logic [1:0]  zcal;
  logic [5:0]  offs;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0]  m_reg [8];
  logic [10:0] m_sh;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  serial_param_slave i_serial_param_slave (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .load_i(load),
    .edge_mode_o(edge_mode), .edge_dir_o(edge_dir), .gain_o(gain), .expo_o(expo),
    .kern_p_o(kp), .kern_m_o(km), .kern_x_o(kx), .ratio_o(ratio),
    .invert_o(invert), .bias_o(bias), .zero_cal_o(zcal), .offset_o(offs)
  );

  task automatic check(input string req);
    logic [63:0] act, exp_v;
    act = {edge_mode, edge_dir, gain, expo, kp, km, kx, ratio, invert, bias, zcal, offs};
    // field positions per R5..R8
    exp_v = {m_reg[1][7], m_reg[1][6:5], m_reg[1][4:0], m_reg[2], m_reg[3],
             m_reg[4], m_reg[5], m_reg[6], m_reg[7][7:4], m_reg[7][3], m_reg[7][2:0],
             m_reg[0][7:6], m_reg[0][5:0]};
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    m_sh = '0;
  endtask

  // one clock: drive in low phase, check after rise (old) and after fall (new)
  task automatic step(input logic s, input logic l, input string req);
    sdata = s;
    load  = l;
    @(posedge clk); #1;
    check({req, " R3 held at rising edge"});
    m_sh = {m_sh[9:0], s};
    if (l) m_reg[m_sh[10:8]] = m_sh[7:0];
    @(negedge clk); #1;
    check(req);
  endtask

  task automatic send_word(input logic [2:0] a, input logic [7:0] d, input string req);
    logic [10:0] w;
    w = {a, d};
    for (int i = 10; i >= 0; i--) step(w[i], (i == 0), req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_clear();
    #1;
    check("R9 async clear");
    @(posedge clk); @(posedge clk); @(negedge clk); #1;
    rst_n = 1'b1;
    check("R9 after release");
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    done = 1'b1;
  end

  initial begin
    model_clear();
    #1;
    check("R9 reset state");
    @(negedge clk); #1;
    rst_n = 1'b1;
    check("R9 after release");

    // R1 R5 R6 R7 R8: every address, distinct values
    send_word(3'd1, 8'hB5, "R5 edge/gain");
    send_word(3'd2, 8'h9C, "R8 exposure high");
    send_word(3'd3, 8'h47, "R8 exposure low");
    send_word(3'd4, 8'h12, "R7 kernel p");
    send_word(3'd5, 8'hE3, "R7 kernel m");
    send_word(3'd6, 8'h7A, "R7 kernel x");
    send_word(3'd7, 8'h6D, "R6 misc");
    send_word(3'd0, 8'hC9, "R6 offset");
    send_word(3'd2, 8'h01, "R1 rewrite");

    // R4: long traffic without load
    for (int i = 0; i < 40; i++) step(i[0] ^ i[2], 1'b0, "R4 no load");

    // R10: more than 11 bits, only last 11 matter
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, "R10 prefix");
    send_word(3'd5, 8'h0F, "R10 long run");

    // R10: early load after 4 bits
    step(1'b1, 1'b0, "R10 short");
    step(1'b0, 1'b0, "R10 short");
    step(1'b1, 1'b0, "R10 short");
    step(1'b1, 1'b1, "R10 early load");

    // R11: consecutive loads
    for (int i = 0; i < 12; i++) step(i[1], 1'b1, "R11 back to back");

    // R9: reset mid traffic, then short load uses cleared window
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R9 pre traffic");
    do_reset();
    step(1'b1, 1'b0, "R10 after reset");
    step(1'b1, 1'b1, "R10 after reset load");

    // R2: mixed traffic
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], (lfsr[5:3] == 3'b101), "R2 mixed");
    end

    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule